// File: doc/BRIEF.md
# Write-once nonvolatile memory clock divider

This block derives the slow timing tick that erase and program sequencing logic for a nonvolatile memory needs. It takes that tick from the bus clock. An 8-bit configuration register holds two fields: a prescale select that places a fixed divide-by-8 ahead of the divider, and a 6-bit divisor. The tick rate is the bus clock divided by (divisor + 1), or by 8 × (divisor + 1) when the prescaler is selected. The tick is a one-bus-cycle enable pulse, not a generated clock, so everything stays in one clock domain. Downstream sequencers count an integer number of these ticks to time an operation.

The configuration fields accept only the first write after reset. That write also sets a read-only loaded flag, whatever data it carries. The flag drives a permission output. Until the register has been written, the permission output stays low and no tick is produced, so erase and program are locked out. The prescaler and divider counters start from zero when the flag sets. The first tick therefore comes one full divided period after the configuring write.

Top module: `nvm_tick_divider`

## Requirements
- R1: While reset is active and right after it, `pe_allow` is 0, `tick` is 0, and a read returns 0x00.
- R2: While `rd_en` is high, `rdata` shows in the same cycle the loaded flag in bit 7, the prescale select in bit 6 and the divisor in bits 5:0. While `rd_en` is low, `rdata` is 0x00.
- R3: The first write after reset stores `wdata[6:0]` and sets the loaded flag from the next cycle on, for any data including 0x00. `wdata[7]` is ignored.
- R4: Once the flag is set, later writes leave bits 6:0 unchanged, as a read afterwards shows.
- R5: `pe_allow` equals the loaded flag at all times.
- R6: `tick` stays low while the loaded flag is clear.
- R7: With prescale 0 and divisor D > 0, `tick` is one cycle wide and repeats every D+1 bus cycles. The first tick is sampled at the (D+1)-th rising edge after the edge that took the write.
- R8: With prescale 1 and divisor D, `tick` repeats every 8×(D+1) bus cycles. The first tick is sampled at the 8×(D+1)-th edge after the write.
- R9: With prescale 0 and divisor 0, `tick` is high on every cycle from the cycle after the write.
- R10: Reads have no side effect on the flag, the fields or the tick phase. A read in the same cycle as the first write returns the contents from before the write.
- R11: With a 50 MHz bus clock, prescale 1 and divisor 35, the tick period lies between 5.0 µs and 6.7 µs (150 kHz to 200 kHz).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data: bit 6 prescale select, bits 5:0 divisor, bit 7 ignored |
| rd_en | input | 1 | Register read strobe |
| rdata | output | 8 | Read data: flag, prescale select, divisor; 0 when not reading |
| tick | output | 1 | One-cycle divided timing enable |
| pe_allow | output | 1 | Erase/program permission, follows the loaded flag |

## Verification
The bench builds the block with its defaults: a 6-bit divisor and a 3-bit prescale counter (ratio 8). These values reach both ends of the divisor range, every-cycle ticking and the longest period of 512 cycles. At 50 MHz they also reach a setting inside the 150 to 200 kHz window, which the bench times in nanoseconds. Each configuration takes its own reset, because the register accepts only one write per reset. The bench also sends second writes, reads in the same cycle as a write, and a write of all zeros.

// File: rtl/nvm_div_pkg.sv
package nvm_div_pkg;

   typedef enum logic {
      PRE_BYPASS  = 1'b0,
      PRE_ENGAGED = 1'b1
   } pre_sel_e;

   function automatic int unsigned reg_width(input int unsigned div_w);
      return div_w + 2;
   endfunction

endpackage

// File: rtl/nvm_cfg_once.sv
module nvm_cfg_once
   import nvm_div_pkg::*;
#(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W:0]   wfields,
   output logic             loaded_o,
   output pre_sel_e         pre_o,
   output logic [DIV_W-1:0] div_o
);

   logic             loaded_q;
   pre_sel_e         pre_q;
   logic [DIV_W-1:0] div_q;
   logic             take;

   assign take = wr_en && !loaded_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loaded_q <= 1'b0;
         pre_q    <= PRE_BYPASS;
         div_q    <= '0;
      end else if (take) begin
         loaded_q <= 1'b1;
         pre_q    <= pre_sel_e'(wfields[DIV_W]);
         div_q    <= wfields[DIV_W-1:0];
      end
   end

   assign loaded_o = loaded_q;
   assign pre_o    = pre_q;
   assign div_o    = div_q;

endmodule

// File: rtl/nvm_prescale.sv
module nvm_prescale
   import nvm_div_pkg::*;
#(
   parameter int unsigned PRE_LOG2 = 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run_i,
   input  pre_sel_e sel_i,
   output logic     step_o
);

   generate
      if (PRE_LOG2 == 0) begin : g_none
         assign step_o = run_i;
      end else begin : g_cnt
         localparam logic [PRE_LOG2-1:0] LAST = {PRE_LOG2{1'b1}};
         logic [PRE_LOG2-1:0] cnt_q;
         logic                engaged;

         assign engaged = run_i && (sel_i == PRE_ENGAGED);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (engaged) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign step_o = (sel_i == PRE_ENGAGED) ? (engaged && (cnt_q == LAST))
                                                : run_i;
      end
   endgenerate

endmodule

// File: rtl/nvm_div_count.sv
module nvm_div_count #(
   parameter int unsigned DIV_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic [DIV_W-1:0] limit_i,
   output logic             tick_o
);

   logic [DIV_W-1:0] cnt_q;
   logic             hit;

   assign hit = step_i && (cnt_q == limit_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (hit) begin
         cnt_q <= '0;
      end else if (step_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = hit;

endmodule

// File: rtl/nvm_tick_divider.sv
module nvm_tick_divider
   import nvm_div_pkg::*;
#(
   parameter int unsigned DIV_W    = 6,
   parameter int unsigned PRE_LOG2 = 3,
   localparam int unsigned REG_W   = DIV_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   input  logic             rd_en,
   output logic [REG_W-1:0] rdata,
   output logic             tick,
   output logic             pe_allow
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("nvm_tick_divider: DIV_W must be at least 1");
      end
      if (PRE_LOG2 > 8) begin : g_bad_pre
         $error("nvm_tick_divider: PRE_LOG2 out of range");
      end
      if (REG_W != reg_width(DIV_W)) begin : g_bad_reg
         $error("nvm_tick_divider: register width mismatch");
      end
   endgenerate

   logic             loaded;
   pre_sel_e         pre_sel;
   logic [DIV_W-1:0] div_val;
   logic             pre_step;

   nvm_cfg_once #(.DIV_W(DIV_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wfields  (wdata[DIV_W:0]),
      .loaded_o (loaded),
      .pre_o    (pre_sel),
      .div_o    (div_val)
   );

   nvm_prescale #(.PRE_LOG2(PRE_LOG2)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (loaded),
      .sel_i  (pre_sel),
      .step_o (pre_step)
   );

   nvm_div_count #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (pre_step),
      .limit_i (div_val),
      .tick_o  (tick)
   );

   assign pe_allow = loaded;
   assign rdata    = rd_en ? {loaded, pre_sel, div_val} : '0;

endmodule

// File: rtl/nvm_tick_divider_chk.sv
module nvm_tick_divider_chk #(
   parameter int unsigned DIV_W = 6,
   localparam int unsigned REG_W = DIV_W + 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic             rd_en,
   input logic [REG_W-1:0] rdata,
   input logic             tick,
   input logic             pe_allow,
   input logic             pre_bit,
   input logic [DIV_W-1:0] div_val
);

   // R6: no tick before the register is loaded
   a_r6_no_tick_unloaded: assert property (@(posedge clk) disable iff (!rst_n)
      !pe_allow |-> !tick);

   // R3: a write while unloaded sets the flag
   a_r3_first_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !pe_allow) |=> pe_allow);

   // R5: permission never drops outside reset
   a_r5_permission_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      pe_allow |=> pe_allow);

   // R5: permission agrees with the flag seen on a read
   a_r5_flag_matches_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (rdata[REG_W-1] == pe_allow));

   // R4: stored fields frozen once loaded
   a_r4_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (pe_allow && $past(pe_allow)) |-> ($stable(pre_bit) && $stable(div_val)));

   // R7: tick is a single-cycle pulse whenever the period exceeds one cycle
   a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (pre_bit || (div_val != '0))) |=> !tick);

   // R2: no read data without a read strobe
   a_r2_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |-> (rdata == '0));

endmodule

bind nvm_tick_divider nvm_tick_divider_chk #(.DIV_W(DIV_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .rd_en    (rd_en),
   .rdata    (rdata),
   .tick     (tick),
   .pe_allow (pe_allow),
   .pre_bit  (pre_sel),
   .div_val  (div_val)
);

// File: tb/sim_nvm_tick_divider.sv
`timescale 1ns/1ps
module sim_nvm_tick_divider;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic       rd_en = 1'b0;
   logic [7:0] rdata;
   logic       tick;
   logic       pe_allow;

   always #10 clk = ~clk;

   nvm_tick_divider u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wdata    (wdata),
      .rd_en    (rd_en),
      .rdata    (rdata),
      .tick     (tick),
      .pe_allow (pe_allow)
   );

   int n_cmp  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   // behavioural reference
   bit        m_loaded;
   bit        m_pre;
   int        m_div;
   longint    m_n;
   string     rd_tag = "R2";
   bit        range_on = 1'b0;
   realtime   last_tick_t = 0.0;
   int        range_seen = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_loaded = 1'b0;
         m_pre    = 1'b0;
         m_div    = 0;
         m_n      = 0;
      end else begin
         if (m_loaded) m_n++;
         if (wr_en && !m_loaded) begin
            m_loaded = 1'b1;
            m_pre    = wdata[6];
            m_div    = int'(wdata[5:0]);
            m_n      = 0;
         end
      end
   end

   task automatic check(input string tag, input string what,
                        input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         longint per;
         bit     e_tick;
         string  ttag;
         per    = (m_pre ? 8 : 1) * (m_div + 1);
         e_tick = m_loaded && (((m_n + 1) % per) == 0);
         if (!rst_n)        ttag = "R1";
         else if (!m_loaded) ttag = "R6";
         else if (m_pre)    ttag = "R8";
         else if (m_div == 0) ttag = "R9";
         else               ttag = "R7";
         check(ttag, "tick", longint'(tick), longint'(e_tick));
         check(rst_n ? "R5" : "R1", "pe_allow", longint'(pe_allow), longint'(m_loaded));
         if (rd_en)
            check(rst_n ? rd_tag : "R1", "rdata", longint'(rdata),
                  longint'({m_loaded, m_pre, 6'(m_div)}));
         else
            check("R2", "rdata idle", longint'(rdata), 0);
         if (range_on && tick) begin
            if (last_tick_t > 0.0) begin
               range_seen++;
               n_cmp++;
               if ((($realtime - last_tick_t) < 5000.0) || (($realtime - last_tick_t) > 6667.0)) begin
                  n_bad++;
                  $display("FAIL R11 tick period actual=%0t expected 5000..6667 ns",
                           $realtime - last_tick_t);
               end
            end
            last_tick_t = $realtime;
         end
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #5;
   endtask

   task automatic do_reset();
      @(posedge clk); #5;
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
      step(3);
      rst_n = 1'b1;
      rd_tag = "R1";
      rd_en = 1'b1;
      step(1);
      rd_en = 1'b0;
      rd_tag = "R2";
      step(2);
   endtask

   task automatic do_write(input logic [7:0] v, input bit with_rd);
      wr_en = 1'b1; wdata = v; rd_en = with_rd;
      step(1);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   task automatic do_read(input string tag);
      rd_tag = tag;
      rd_en = 1'b1;
      step(1);
      rd_en = 1'b0;
      rd_tag = "R2";
   endtask

   initial begin
      step(1);
      // R1: reset values observed during and after reset
      do_reset();
      step(10);                               // R6: idle, no tick

      // R9, R3: all-zero write still loads; every-cycle tick
      rd_tag = "R10";
      do_write(8'h00, 1'b1);                  // R10: read beside write shows old contents
      do_read("R3");
      step(20);

      // R7, R3, R4: bit 7 ignored, D=5, second write ignored
      do_reset();
      do_write(8'h85, 1'b0);
      do_read("R3");
      step(13);
      do_write(8'h3F, 1'b0);
      do_read("R4");
      do_write(8'h41, 1'b0);
      do_read("R4");
      step(30);

      // R8: prescale on, D=2, reads interleaved (R10)
      do_reset();
      do_write(8'h42, 1'b0);
      for (int i = 0; i < 10; i++) begin
         do_read("R10");
         step(7);
      end

      // R7: largest divisor without prescale
      do_reset();
      do_write(8'h3F, 1'b0);
      step(200);

      // R11: 50 MHz, prescale on, D=35 -> 288 cycles
      do_reset();
      range_on = 1'b1;
      do_write(8'h63, 1'b0);
      step(1000);
      range_on = 1'b0;
      n_cmp++;
      if (range_seen < 2) begin
         n_bad++;
         $display("FAIL R11 tick intervals actual=%0d expected>=2", range_seen);
      end

      // R8: longest period, 512 cycles
      do_reset();
      do_write(8'h7F, 1'b0);
      step(1100);
      do_read("R4");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule